// File: doc/BRIEF.md
# Scrolling viewport video address generator

This block produces frame-buffer read addresses for a raster display whose visible screen is a movable window inside a larger canvas. The canvas is stored row after row in memory, each row `pitch` memory words long. For every fetch group of pixels, the block adds the screen-local raster position to a viewport origin. It wraps the horizontal sum at the canvas width and the vertical sum at a programmable line count. It then forms `base + row * pitch + column` and presents the result with a fetch strobe.

Scrolling moves the origin and does not copy pixel data. Moving the origin one word horizontally, or one line vertically, scrolls the image by that amount. Scrolling is whole-word only. With `PPW_LOG2 = 1`, each 16-bit word carries two 8-bit pixels, so a fetch is issued on every even pixel column.

A host writes five registers through a synchronous select/data/write-enable port. Base, pitch and line count take effect at once. The origin registers are double-buffered: a write changes a shadow copy, which is transferred to the working copy on the rising edge of the vertical blanking flag. This keeps the picture from tearing part-way through a frame.

Top module: `vp_addr_gen`

## Requirements
- R1: After reset, `fetch_stb` is 0, `fetch_addr` is 0, and all five registers and both origin copies are 0.
- R2: `fetch_stb` is 1 in the cycle after a clock edge that samples `active` = 1 with the low `PPW_LOG2` bits of `pix_x` all zero. Otherwise it is 0.
- R3: Given word column `c` and row `r`, `fetch_addr` equals `(base + r * pitch + c) mod 2^AW` one clock after the sampled position. Here the word column is `pix_x >> PPW_LOG2`.
- R4: The column is `word_x + gx`, reduced by `pitch` once if it is at least `pitch`. A window that extends past the right edge therefore reads from the left edge of the canvas. The reduction is exact for `gx < pitch` and `word_x < pitch`.
- R5: The row is `pix_y + gy`, reduced by `lines` once if it is at least `lines`. The output therefore wraps to the start of the buffer after `lines` canvas lines. The reduction is exact for `gy < lines` and `pix_y < lines`.
- R6: Writes to select 3 (`gx`) or select 4 (`gy`) do not change the address until the next rising edge of `vblank`. At that edge the written values take effect.
- R7: Writes to select 0 (`base`), select 1 (`pitch`) and select 2 (`lines`) apply to addresses computed from the next clock on.
- R8: Writes with select values 5, 6 and 7 change no register.
- R9: While `fetch_stb` is 0, `fetch_addr` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write enable |
| reg_sel | input | 3 | Register select: 0 base, 1 pitch, 2 lines, 3 gx, 4 gy |
| reg_wdata | input | AW | Write data (low CW bits used except for base) |
| pix_x | input | CW | Screen-local pixel column |
| pix_y | input | CW | Screen-local line |
| active | input | 1 | Active-video flag |
| vblank | input | 1 | Vertical blanking flag; its rising edge loads the origin |
| fetch_addr | output | AW | Word address of the fetch |
| fetch_stb | output | 1 | Fetch request |

## Verification
The bench builds the block with AW = 16, CW = 10 and PPW_LOG2 = 1. At these values every odd pixel column must be skipped, and a 64-word pitch with a 100-line canvas puts both wrap edges within a few fetches of an easily chosen origin. It also lets the base-plus-offset sum reach past 2^16, so the modular truncation can be seen. The origins 62 and 98 sit two words and two lines short of the edges, so each wrap is crossed within a four-fetch scan.

// File: rtl/vp_addr_gen.sv
module vp_addr_gen #(
  parameter int AW       = 20,
  parameter int CW       = 12,
  parameter int PPW_LOG2 = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_sel,
  input  logic [AW-1:0] reg_wdata,
  input  logic [CW-1:0] pix_x,
  input  logic [CW-1:0] pix_y,
  input  logic          active,
  input  logic          vblank,
  output logic [AW-1:0] fetch_addr,
  output logic          fetch_stb
);

  localparam logic [CW-1:0] GMASK = CW'((1 << PPW_LOG2) - 1);

  logic [AW-1:0] base_r;
  logic [CW-1:0] pitch_r, lines_r;
  logic [CW-1:0] gx_sh, gy_sh, gx_act, gy_act;
  logic          vblank_d;

  wire vb_rise = vblank & ~vblank_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_r  <= '0;
      pitch_r <= '0;
      lines_r <= '0;
      gx_sh   <= '0;
      gy_sh   <= '0;
    end else if (reg_we) begin
      case (reg_sel)
        3'd0:    base_r  <= reg_wdata;
        3'd1:    pitch_r <= reg_wdata[CW-1:0];
        3'd2:    lines_r <= reg_wdata[CW-1:0];
        3'd3:    gx_sh   <= reg_wdata[CW-1:0];
        3'd4:    gy_sh   <= reg_wdata[CW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vblank_d <= 1'b0;
      gx_act   <= '0;
      gy_act   <= '0;
    end else begin
      vblank_d <= vblank;
      if (vb_rise) begin
        gx_act <= gx_sh;
        gy_act <= gy_sh;
      end
    end
  end

  wire [CW-1:0] word_x = pix_x >> PPW_LOG2;
  wire [CW:0]   csum   = {1'b0, word_x} + {1'b0, gx_act};
  wire [CW:0]   rsum   = {1'b0, pix_y} + {1'b0, gy_act};
  wire [CW:0]   col    = (csum >= {1'b0, pitch_r}) ? csum - {1'b0, pitch_r} : csum;
  wire [CW:0]   row    = (rsum >= {1'b0, lines_r}) ? rsum - {1'b0, lines_r} : rsum;
  wire [AW-1:0] lin    = base_r + AW'(row) * AW'(pitch_r) + AW'(col);
  wire          hit    = active && ((pix_x & GMASK) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_stb  <= 1'b0;
      fetch_addr <= '0;
    end else begin
      fetch_stb <= hit;
      if (hit) fetch_addr <= lin;
    end
  end

  AST_STB_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stb |-> $past(active)); // R2
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_stb |-> $stable(fetch_addr)); // R9
  AST_ORIGIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(vb_rise) |-> ($stable(gx_act) && $stable(gy_act))); // R6
  AST_COL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && gx_act < pitch_r && word_x < pitch_r) |-> (col < {1'b0, pitch_r})); // R4
  AST_ROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && gy_act < lines_r && pix_y < lines_r) |-> (row < {1'b0, lines_r})); // R5

endmodule

// File: tb/sim_vp_addr_gen.sv
module sim_vp_addr_gen;
  localparam int AW = 16, CW = 10, PPW_LOG2 = 1;

  logic clk = 0, rst_n = 0, reg_we = 0, active = 0, vblank = 0;
  logic [2:0] reg_sel = 0;
  logic [AW-1:0] reg_wdata = 0;
  logic [CW-1:0] pix_x = 0, pix_y = 0;
  logic [AW-1:0] fetch_addr;
  logic fetch_stb;

  always #5 clk = ~clk;

  vp_addr_gen #(.AW(AW), .CW(CW), .PPW_LOG2(PPW_LOG2)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .pix_x(pix_x), .pix_y(pix_y), .active(active),
    .vblank(vblank), .fetch_addr(fetch_addr), .fetch_stb(fetch_stb));

  typedef struct { logic stb; logic [AW-1:0] addr; string tag; } item_t;
  item_t q[$];
  int checks = 0, fails = 0;
  bit armed = 0, done = 0;

  int m_base = 0, m_pitch = 0, m_lines = 0, m_gx = 0, m_gy = 0, s_gx = 0, s_gy = 0;
  logic [AW-1:0] m_addr = 0;

  task automatic push(input logic stb, input string tag);
    item_t it;
    it.stb = stb; it.addr = m_addr; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    reg_we = 0; active = 0; vblank = 0;
    push(1'b0, tag);
  endtask

  task automatic wr(input int sel, input int data, input string tag);
    @(negedge clk);
    active = 0; vblank = 0;
    reg_we = 1; reg_sel = 3'(sel); reg_wdata = AW'(data);
    case (sel)
      0: m_base = data;
      1: m_pitch = data;
      2: m_lines = data;
      3: s_gx = data;
      4: s_gy = data;
      default: ;
    endcase
    push(1'b0, tag);
    @(negedge clk);
    reg_we = 0;
    push(1'b0, tag);
  endtask

  task automatic vb_pulse(input string tag);
    @(negedge clk);
    reg_we = 0; active = 0; vblank = 1;
    m_gx = s_gx; m_gy = s_gy;
    push(1'b0, tag);
    idle(tag);
  endtask

  task automatic pix(input int x, input int y, input string tag);
    int c, r;
    logic stb;
    @(negedge clk);
    reg_we = 0; vblank = 0; active = 1;
    pix_x = CW'(x); pix_y = CW'(y);
    stb = ((x % (1 << PPW_LOG2)) == 0);
    if (stb) begin
      c = (x >> PPW_LOG2) + m_gx; if (c >= m_pitch) c -= m_pitch;
      r = y + m_gy; if (r >= m_lines) r -= m_lines;
      m_addr = AW'(m_base + r * m_pitch + c);
    end
    push(stb, tag);
  endtask

  task automatic scan(input int y, input int n, input string tag);
    for (int x = 0; x < n; x++) pix(x, y, tag);
    idle(tag);
  endtask

  initial begin
    forever begin
      @(posedge clk); #1;
      if (armed && q.size() > 0) begin
        item_t e;
        e = q.pop_front();
        checks++;
        if (fetch_stb !== e.stb || fetch_addr !== e.addr) begin
          fails++;
          $display("FAIL %s: stb=%0b addr=%h expected stb=%0b addr=%h",
                   e.tag, fetch_stb, fetch_addr, e.stb, e.addr);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (fetch_stb !== 1'b0 || fetch_addr !== '0) begin
      fails++;
      $display("FAIL R1: stb=%0b addr=%h expected stb=0 addr=0", fetch_stb, fetch_addr);
    end
    rst_n = 1;
    armed = 1;
    idle("R1");
    scan(0, 4, "R1");
    wr(1, 64, "R7"); wr(2, 100, "R7"); wr(0, 'h100, "R7");
    scan(0, 8, "R3");
    scan(3, 7, "R2");
    idle("R9"); idle("R9");
    wr(3, 5, "R6"); wr(4, 2, "R6");
    scan(1, 4, "R6");
    vb_pulse("R6");
    scan(1, 4, "R6");
    wr(3, 62, "R4"); vb_pulse("R4");
    scan(4, 8, "R4");
    wr(3, 0, "R5"); wr(4, 98, "R5"); vb_pulse("R5");
    for (int y = 1; y < 4; y++) scan(y, 2, "R5");
    wr(0, 'hFF00, "R7");
    scan(5, 4, "R7");
    wr(2, 50, "R7");
    scan(1, 2, "R7");
    wr(5, 7, "R8"); wr(6, 'h1234, "R8"); wr(7, 3, "R8");
    scan(2, 4, "R8");
    vb_pulse("R8");
    scan(2, 2, "R8");
    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not finish");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule